// File: doc/BRIEF.md
# Multi-Block Command Dispatcher

This block sits between a host command port and several independent per-block operation controllers in a storage array. The host first loads an opcode. It then drives an address and finally strikes a go pulse with its data word. The dispatcher selects the owning block from the upper field of the address and passes the command to that block's controller. Because every block runs on its own, a long erase on one block does not hold back a read or a program on another.

Each block has its own small FIFO. A command for a block that is idle and has nothing queued goes straight through in the same cycle. A command for a busy block waits in that block's FIFO and leaves as soon as the controller drops its busy line. The address register tracks the host bus and loads only when the bus shows a different, in-range address. An out-of-range target is refused with an error flag.

Top module: `cd_dispatch`

## Requirements
- R1: After reset no issue strobe is high, `host_rdy` is 1 and `host_err` is 0.
- R2: `host_op_we` loads `host_op` into the opcode register at the clock edge. A go pulse carries the opcode held before that edge, so an opcode written in the same cycle as go is not used. Opcode codes are 0 read, 1 program and 2 erase.
- R3: An address is split as {block[BLK_W-1:0], offset[OFF_W-1:0]}, block in the upper bits. The held address loads `host_addr` at a clock edge only when the bus differs from the held value and its block field is below NBLK. A go pulse targets the held address from before that edge.
- R4: A go pulse while the block field of `host_addr` is NBLK or above raises `host_err` in the same cycle, and the command is discarded without being issued.
- R5: A block is ready when its `lc_busy` bit is 0 and it was not issued to in the previous cycle. A go pulse to a ready block with an empty FIFO raises that block's `iss_valid` in the same cycle with the opcode, offset and data.
- R6: A command to a block that is not ready, or whose FIFO is not empty, is queued. A ready block with a non-empty FIFO issues its oldest entry. After any issue the block is not issued to in the next cycle.
- R7: Commands to the same block leave in the order they were accepted, each with its own opcode, offset and data.
- R8: `host_rdy` is 0 while the FIFO of the held target block holds DEPTH entries. A go pulse during that time is ignored.
- R9: Blocks are independent: a command to an idle block issues at once while another block is busy.
- R10: No `iss_valid` bit is high while the matching `lc_busy` bit is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| host_op_we | input | 1 | Load strobe for the opcode register |
| host_op | input | OP_W (2) | Opcode value |
| host_addr | input | BLK_W+OFF_W | Host address bus {block, offset} |
| host_go | input | 1 | Command strike, uses the held opcode and address |
| host_data | input | DATA_W | Data word sampled with go |
| host_rdy | output | 1 | Target FIFO can take a command |
| host_err | output | 1 | Go seen with an out-of-range block field |
| lc_busy | input | NBLK | Busy line from each local controller |
| iss_valid | output | NBLK | One-cycle issue strobe per block |
| iss_op | output | NBLK*OP_W | Opcode per block |
| iss_off | output | NBLK*OFF_W | Address offset per block |
| iss_data | output | NBLK*DATA_W | Data per block |

## Verification
A corrupt FIFO pointer or count shows up at the next issue from that block. The strobe then carries the wrong payload or an out-of-order entry, or it fires when nothing was accepted. A stuck count can also hold `host_rdy` low after the block has drained. A held address that loads when it should not sends a later go to the wrong block, or with the wrong offset, in the very cycle of that go. A lost ready-gap flag shows as an issue in the cycle right after an earlier issue, so the fault appears at the port one cycle after the first strobe.

// File: rtl/cd_pkg.sv
package cd_pkg;
  localparam int OP_W = 2;
  typedef enum logic [OP_W-1:0] {
    OP_READ  = 2'd0,
    OP_PROG  = 2'd1,
    OP_ERASE = 2'd2,
    OP_RSVD  = 2'd3
  } op_e;
endpackage

// File: rtl/cd_fifo.sv
module cd_fifo #(
  parameter int W     = 14,
  parameter int DEPTH = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push,
  input  logic         pop,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout,
  output logic         empty,
  output logic         full
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [W-1:0]  mem [DEPTH];
  logic [PW-1:0] rd_q, rd_d, wr_q, wr_d;
  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    rd_d  = rd_q;
    wr_d  = wr_q;
    cnt_d = cnt_q;
    if (pop)  rd_d = (rd_q == PW'(DEPTH - 1)) ? '0 : rd_q + 1'b1;
    if (push) wr_d = (wr_q == PW'(DEPTH - 1)) ? '0 : wr_q + 1'b1;
    if (push && !pop)      cnt_d = cnt_q + 1'b1;
    else if (pop && !push) cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_q  <= '0;
      wr_q  <= '0;
      cnt_q <= '0;
    end else begin
      rd_q  <= rd_d;
      wr_q  <= wr_d;
      cnt_q <= cnt_d;
    end
  end

  always_ff @(posedge clk) begin
    if (push) mem[wr_q] <= din;
  end

  assign dout  = mem[rd_q];
  assign empty = (cnt_q == '0);
  assign full  = (cnt_q == CW'(DEPTH));
endmodule

// File: rtl/cd_lane.sv
module cd_lane #(
  parameter int W     = 14,
  parameter int DEPTH = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         go_hit,
  input  logic [W-1:0] cmd_in,
  input  logic         busy_in,
  output logic         iss_valid,
  output logic [W-1:0] iss_cmd,
  output logic         q_full,
  output logic         q_empty
);
  logic         issued_q, issued_d;
  logic         ready, from_q, bypass, push;
  logic [W-1:0] head;

  assign ready  = !busy_in && !issued_q;
  assign from_q = ready && !q_empty;
  assign bypass = ready && q_empty && go_hit;
  assign push   = go_hit && !bypass;

  cd_fifo #(.W(W), .DEPTH(DEPTH)) u_fifo (
    .clk(clk), .rst_n(rst_n), .push(push), .pop(from_q),
    .din(cmd_in), .dout(head), .empty(q_empty), .full(q_full)
  );

  assign iss_valid = from_q || bypass;
  assign iss_cmd   = from_q ? head : cmd_in;
  assign issued_d  = iss_valid;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) issued_q <= 1'b0;
    else        issued_q <= issued_d;
  end
endmodule

// File: rtl/cd_addr_latch.sv
module cd_addr_latch #(
  parameter int NBLK  = 3,
  parameter int BLK_W = 2,
  parameter int OFF_W = 4
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [BLK_W+OFF_W-1:0] addr_in,
  output logic [BLK_W+OFF_W-1:0] addr_q,
  output logic                   in_range
);
  localparam int ADDR_W = BLK_W + OFF_W;

  logic [ADDR_W-1:0] addr_d;
  logic [BLK_W-1:0]  blk;
  logic              change;

  assign blk      = addr_in[ADDR_W-1 -: BLK_W];
  assign in_range = (32'(blk) < NBLK);
  assign change   = (addr_in != addr_q);

  always_comb begin
    addr_d = addr_q;
    if (change && in_range) addr_d = addr_in;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) addr_q <= '0;
    else        addr_q <= addr_d;
  end
endmodule

// File: rtl/cd_dispatch.sv
module cd_dispatch
  import cd_pkg::*;
#(
  parameter int NBLK   = 3,
  parameter int BLK_W  = 2,
  parameter int OFF_W  = 4,
  parameter int DATA_W = 8,
  parameter int DEPTH  = 4
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    host_op_we,
  input  logic [OP_W-1:0]         host_op,
  input  logic [BLK_W+OFF_W-1:0]  host_addr,
  input  logic                    host_go,
  input  logic [DATA_W-1:0]       host_data,
  output logic                    host_rdy,
  output logic                    host_err,
  input  logic [NBLK-1:0]         lc_busy,
  output logic [NBLK-1:0]         iss_valid,
  output logic [NBLK*OP_W-1:0]    iss_op,
  output logic [NBLK*OFF_W-1:0]   iss_off,
  output logic [NBLK*DATA_W-1:0]  iss_data
);
  localparam int ADDR_W = BLK_W + OFF_W;
  localparam int CMD_W  = OP_W + OFF_W + DATA_W;

  logic              rst_s0, rst_i_n;
  logic [OP_W-1:0]   op_q, op_d;
  logic [ADDR_W-1:0] addr_q;
  logic              bus_ok, accept;
  logic [BLK_W-1:0]  tgt;
  logic [NBLK-1:0]   go_hit, q_full, q_empty;
  logic [CMD_W-1:0]  cmd_in;
  logic [CMD_W-1:0]  lane_cmd [NBLK];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_s0  <= 1'b0;
      rst_i_n <= 1'b0;
    end else begin
      rst_s0  <= 1'b1;
      rst_i_n <= rst_s0;
    end
  end

  always_comb begin
    op_d = op_q;
    if (host_op_we) op_d = host_op;
  end

  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) op_q <= '0;
    else          op_q <= op_d;
  end

  cd_addr_latch #(.NBLK(NBLK), .BLK_W(BLK_W), .OFF_W(OFF_W)) u_latch (
    .clk(clk), .rst_n(rst_i_n), .addr_in(host_addr),
    .addr_q(addr_q), .in_range(bus_ok)
  );

  assign tgt = addr_q[ADDR_W-1 -: BLK_W];

  always_comb begin
    host_rdy = 1'b1;
    for (int b = 0; b < NBLK; b++) begin
      if (tgt == BLK_W'(b)) host_rdy = !q_full[b];
    end
  end

  assign host_err = host_go && !bus_ok;
  assign accept   = host_go && bus_ok && host_rdy;
  assign cmd_in   = {op_q, addr_q[OFF_W-1:0], host_data};

  for (genvar b = 0; b < NBLK; b++) begin : g_lane
    assign go_hit[b] = accept && (tgt == BLK_W'(b));

    cd_lane #(.W(CMD_W), .DEPTH(DEPTH)) u_lane (
      .clk(clk), .rst_n(rst_i_n), .go_hit(go_hit[b]), .cmd_in(cmd_in),
      .busy_in(lc_busy[b]), .iss_valid(iss_valid[b]), .iss_cmd(lane_cmd[b]),
      .q_full(q_full[b]), .q_empty(q_empty[b])
    );

    assign iss_op[b*OP_W +: OP_W]       = lane_cmd[b][CMD_W-1 -: OP_W];
    assign iss_off[b*OFF_W +: OFF_W]    = lane_cmd[b][DATA_W +: OFF_W];
    assign iss_data[b*DATA_W +: DATA_W] = lane_cmd[b][DATA_W-1:0];
  end
endmodule

// File: rtl/cd_dispatch_chk.sv
module cd_dispatch_chk #(
  parameter int NBLK  = 3,
  parameter int BLK_W = 2,
  parameter int OFF_W = 4
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic [BLK_W+OFF_W-1:0] host_addr,
  input logic [BLK_W+OFF_W-1:0] addr_q,
  input logic [NBLK-1:0]        lc_busy,
  input logic [NBLK-1:0]        iss_valid,
  input logic [NBLK-1:0]        q_empty
);
  localparam int ADDR_W = BLK_W + OFF_W;

  assert_no_busy_issue_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (iss_valid & lc_busy) == '0);

  assert_gap_after_issue_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (|iss_valid) |=> ((iss_valid & $past(iss_valid)) == '0));

  assert_hold_on_bad_addr_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (32'(host_addr[ADDR_W-1 -: BLK_W]) >= NBLK) |=> $stable(addr_q));

  for (genvar b = 0; b < NBLK; b++) begin : g_chk
    assert_drain_when_ready_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (!q_empty[b] && !lc_busy[b] && !$past(iss_valid[b])) |-> iss_valid[b]);
  end
endmodule

bind cd_dispatch cd_dispatch_chk #(.NBLK(NBLK), .BLK_W(BLK_W), .OFF_W(OFF_W)) u_chk (
  .clk(clk), .rst_n(rst_i_n), .host_addr(host_addr), .addr_q(addr_q),
  .lc_busy(lc_busy), .iss_valid(iss_valid), .q_empty(q_empty)
);

// File: tb/sim_cd_dispatch.sv
module sim_cd_dispatch;
  import cd_pkg::*;

  logic       clk, rst_n, op_we, go;
  logic [1:0] op;
  logic [5:0] addr;
  logic [7:0] data;
  logic [2:0] lc_busy;
  logic       host_rdy, host_err;
  logic [2:0] iss_valid;
  logic [5:0] iss_op;
  logic [11:0] iss_off;
  logic [23:0] iss_data;

  cd_dispatch u0 (
    .clk(clk), .rst_n(rst_n), .host_op_we(op_we), .host_op(op), .host_addr(addr),
    .host_go(go), .host_data(data), .host_rdy(host_rdy), .host_err(host_err),
    .lc_busy(lc_busy), .iss_valid(iss_valid), .iss_op(iss_op),
    .iss_off(iss_off), .iss_data(iss_data)
  );

  int n_chk = 0, n_err = 0;
  bit done = 0;
  logic [13:0] exp_mem [3][256];
  int wp [3];
  int rp [3];
  int dur [3];
  int cnt [3];
  bit pend [3];

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] expv);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s: actual %0h expected %0h", req, act, expv);
    end
  endtask

  task automatic tick;
    @(posedge clk); #1;
  endtask

  task automatic push_exp(input int b, input logic [13:0] v);
    exp_mem[b][wp[b]] = v;
    wp[b]++;
  endtask

  // monitor: every issue must match the oldest expected entry of its block
  always @(negedge clk) begin
    for (int b = 0; b < 3; b++) begin
      if (iss_valid[b]) begin
        logic [13:0] got;
        got = {iss_op[b*2 +: 2], iss_off[b*4 +: 4], iss_data[b*8 +: 8]};
        chk(lc_busy[b] == 1'b0, "R10 issue while busy", 32'(lc_busy[b]), 0);
        if (rp[b] == wp[b]) begin
          chk(1'b0, "R7 unexpected issue", 32'(got), 32'(b));
        end else begin
          chk(got == exp_mem[b][rp[b]], "R7 order/content", 32'(got), 32'(exp_mem[b][rp[b]]));
          rp[b]++;
        end
        pend[b] = 1'b1;
      end
    end
  end

  // local controller models
  always @(posedge clk) begin
    #1;
    for (int b = 0; b < 3; b++) begin
      if (pend[b]) begin
        pend[b] = 1'b0;
        cnt[b] = dur[b];
        lc_busy[b] = (dur[b] > 0);
      end else if (cnt[b] > 0) begin
        cnt[b]--;
        if (cnt[b] == 0) lc_busy[b] = 1'b0;
      end
    end
  end

  task automatic load_op(input logic [1:0] o);
    op = o; op_we = 1'b1; tick; op_we = 1'b0;
  endtask

  task automatic set_addr(input logic [5:0] a);
    addr = a; tick;
  endtask

  // mode 0: no timing check, 1: expect bypass now, 2: expect queued
  task automatic send(input logic [1:0] o, input logic [5:0] a, input logic [7:0] d, input int mode);
    int b;
    b = int'(a[5:4]);
    load_op(o);
    set_addr(a);
    while (!host_rdy) tick;
    go = 1'b1; data = d;
    push_exp(b, {o, a[3:0], d});
    @(negedge clk);
    if (mode == 1) chk(iss_valid[b] == 1'b1, "R5 bypass same cycle", 32'(iss_valid), 32'(1 << b));
    if (mode == 2) chk(iss_valid[b] == 1'b0, "R6 queued while busy", 32'(iss_valid), 0);
    tick;
    go = 1'b0;
  endtask

  task automatic finish_run;
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_err++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run;
  end

  initial begin
    logic [15:0] lf;
    rst_n = 1'b0; op_we = 1'b0; go = 1'b0; op = 2'd0; addr = 6'd0; data = 8'd0;
    lc_busy = 3'b000;
    for (int b = 0; b < 3; b++) begin
      wp[b] = 0; rp[b] = 0; dur[b] = 3; cnt[b] = 0; pend[b] = 1'b0;
    end
    repeat (3) tick;
    @(negedge clk);
    chk(iss_valid == 3'b000, "R1 reset issue", 32'(iss_valid), 0);
    chk(host_rdy == 1'b1, "R1 reset rdy", 32'(host_rdy), 1);
    chk(host_err == 1'b0, "R1 reset err", 32'(host_err), 0);
    tick;
    rst_n = 1'b1;
    repeat (4) tick;
    @(negedge clk);
    chk(iss_valid == 3'b000 && host_rdy && !host_err, "R1 after release",
        32'({iss_valid, host_rdy, host_err}), 32'h2);
    tick;

    // bypass into idle block
    send(OP_PROG, {2'd0, 4'h5}, 8'hA5, 1);
    repeat (10) tick;

    // concurrency: block0 long busy, block1 still served at once
    dur[0] = 30;
    send(OP_PROG, {2'd0, 4'h1}, 8'h11, 1);
    send(OP_ERASE, {2'd1, 4'h2}, 8'h22, 1);
    chk(lc_busy[0] == 1'b1, "R9 block0 busy during block1 issue", 32'(lc_busy[0]), 1);
    send(OP_READ, {2'd0, 4'h3}, 8'h33, 2);
    repeat (40) tick;
    dur[0] = 3;

    // fill block2 queue
    dur[2] = 40;
    send(OP_ERASE, {2'd2, 4'h0}, 8'h40, 1);
    for (int i = 0; i < 4; i++) send(2'(i % 3), {2'd2, 4'(i + 1)}, 8'h41 + 8'(i), 2);
    chk(host_rdy == 1'b0, "R8 rdy low when full", 32'(host_rdy), 0);
    go = 1'b1; data = 8'hFF; tick; go = 1'b0;
    repeat (260) tick;
    chk(rp[2] == wp[2] && wp[2] == 5, "R8 ignored go not issued", 32'(rp[2]), 32'(wp[2]));
    chk(host_rdy == 1'b1, "R8 rdy back after drain", 32'(host_rdy), 1);
    dur[2] = 3;

    // address latch behaviour and opcode ordering
    load_op(OP_READ);
    set_addr({2'd0, 4'h3});
    set_addr({2'd3, 4'h1});
    addr = {2'd1, 4'h7}; go = 1'b1; data = 8'h3C;
    push_exp(0, {2'd0, 4'h3, 8'h3C});
    @(negedge clk);
    chk(iss_valid == 3'b001, "R3 go uses previously held address", 32'(iss_valid), 1);
    chk(iss_off[3:0] == 4'h3, "R3 held offset", 32'(iss_off[3:0]), 3);
    tick; go = 1'b0;
    op = OP_ERASE; op_we = 1'b1; go = 1'b1; data = 8'h5A;
    push_exp(1, {2'd0, 4'h7, 8'h5A});
    @(negedge clk);
    chk(iss_valid == 3'b010, "R3 new address latched", 32'(iss_valid), 2);
    chk(iss_op[3:2] == 2'd0, "R2 same-cycle opcode not used", 32'(iss_op[3:2]), 0);
    tick; go = 1'b0; op_we = 1'b0;
    repeat (8) tick;
    go = 1'b1; data = 8'h6B;
    push_exp(1, {2'd2, 4'h7, 8'h6B});
    @(negedge clk);
    chk(iss_op[3:2] == 2'd2, "R2 loaded opcode used", 32'(iss_op[3:2]), 2);
    tick; go = 1'b0;
    repeat (8) tick;

    // out-of-range target
    set_addr({2'd3, 4'h9});
    go = 1'b1; data = 8'hEE;
    @(negedge clk);
    chk(host_err == 1'b1, "R4 error on bad block", 32'(host_err), 1);
    chk(iss_valid == 3'b000, "R4 nothing issued", 32'(iss_valid), 0);
    tick; go = 1'b0;
    @(negedge clk);
    chk(host_err == 1'b0, "R4 error clears", 32'(host_err), 0);
    tick;
    repeat (10) tick;
    chk(rp[0] == wp[0] && rp[1] == wp[1] && rp[2] == wp[2], "R4 bad command dropped",
        32'(rp[0] + rp[1] + rp[2]), 32'(wp[0] + wp[1] + wp[2]));

    // sweep over blocks, opcodes and busy lengths
    lf = 16'hACE1;
    for (int i = 0; i < 60; i++) begin
      int b;
      lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
      b = int'(lf[7:0]) % 3;
      dur[b] = int'(lf[11:8]) % 6;
      send(2'(int'(lf[15:12]) % 3), {2'(b), lf[3:0]}, lf[15:8] ^ 8'(i), 0);
    end
    repeat (400) tick;
    for (int b = 0; b < 3; b++)
      chk(rp[b] == wp[b], "R6 all queued commands drained", 32'(rp[b]), 32'(wp[b]));
    finish_run;
  end
endmodule